// File: doc/BRIEF.md
# Status Word and Banked Stack Pointer

This block keeps a processor's status word together with two physical stack pointers, one for kernel mode and one for user mode. Two of the status bits control the machine's privilege and interrupt handling. The supervisor flag is active low: 0 means kernel mode. The interrupt-mask flag is also active low: 0 means interrupts are enabled. Microcode can set or clear either flag on its own through a 2-bit latch field. That field shares its control-word bits with the bus-interface direction field, so the block decodes it only while the bus interface is switched off. The value written to the flag is taken from the ALU bus, which microcode drives to all zeros or all ones.

Software and microcode see a single stack pointer. Every write, increment and decrement goes to the kernel pointer while the supervisor flag is low, and to the user pointer otherwise. The pointer that is not selected keeps its value, so a mode switch brings back the other mode's pointer exactly as it was left. The whole status word can also be loaded in parallel, for example when it is restored on a return from an interrupt. It can be read onto the right operand bus with select code 1.

Top module: `msw_sp_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word becomes all zeros except the interrupt-mask bit (bit 4), which becomes 1. The supervisor bit (bit 5) is 0, and both stack pointers become 0.
- R2: With `bif_off`=1, `ctl_mode`=0 and no whole-word load, the next edge copies `alu_bus[0]` into bit 4 (interrupt mask). All other status bits are unchanged.
- R3: With `bif_off`=1, `ctl_mode`=1 and no whole-word load, the next edge copies `alu_bus[0]` into bit 5 (supervisor). All other status bits are unchanged.
- R4: Without a whole-word load, `ctl_mode` values 2 and 3 leave the status word unchanged. Any `ctl_mode` value while `bif_off`=0 also leaves it unchanged.
- R5: `msw_load`=1 loads `msw_din` into the whole status word at the next edge. This takes priority over a single-flag latch in the same cycle.
- R6: `sp_op` encodes 0=hold, 1=write `sp_din`, 2=increment, 3=decrement, all modulo 2^16. The operation acts on the kernel pointer when bit 5 is 0 and on the user pointer when bit 5 is 1. `sp_q` always shows the pointer selected by bit 5.
- R7: The pointer that is not selected keeps its value across any number of cycles and mode switches.
- R8: With `rsel`=1, `rbus_q` shows the status word and `rbus_oe` is 1. With any other `rsel` value, `rbus_q` is 0 and `rbus_oe` is 0.
- R9: When a stack operation and a change of bit 5 fall in the same cycle, the operation uses the bank selected by bit 5 before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bif_off | input | 1 | 1 = bus interface disabled, so the shared field means the latch code |
| ctl_mode | input | 2 | Shared control bits: latch code when `bif_off`=1 |
| alu_bus | input | 16 | ALU result bus; bit 0 is the flag value |
| msw_load | input | 1 | Load the whole status word |
| msw_din | input | 16 | Whole-word load value |
| sp_op | input | 2 | Stack pointer operation |
| sp_din | input | 16 | Stack pointer write value |
| rsel | input | 3 | Right operand bus source select |
| sp_q | output | 16 | Currently selected stack pointer |
| msw_q | output | 16 | Status word |
| sup_n | output | 1 | Supervisor flag (0 = kernel) |
| imask_n | output | 1 | Interrupt-mask flag (0 = enabled) |
| rbus_q | output | 16 | Right bus data from this block |
| rbus_oe | output | 1 | This block drives the right bus |

## Verification
Two pairs of functions can coincide in one cycle. The first is a whole-word load together with a single-flag latch. The second is a stack pointer operation together with a flip of the supervisor flag, whether that flip comes from a latch or from a load. Directed steps force each pair: a load with `ctl_mode`=0 or 1 and the opposite flag value on the ALU bus, and a decrement issued together with a latch of S. A long pseudo-random run then mixes all inputs. On every clock a behavioural model that reads the mode before the edge predicts the status word, the visible pointer and the right-bus outputs. Any disagreement about load priority, or about which bank took the operation, shows up in the next cycle's outputs.

// File: rtl/msw_sp_pkg.sv
// Package msw_sp_pkg
// Shared encodings for the status-word / banked stack pointer block.
// Assumes: a 2-bit latch code and a 2-bit stack operation code.
package msw_sp_pkg;

    // Single-flag latch selection carried in the shared control bits
    typedef enum logic [1:0] {
        LT_IMASK = 2'd0,
        LT_SUP   = 2'd1,
        LT_SPARE = 2'd2,
        LT_NONE  = 2'd3
    } latch_code_e;

    // Stack pointer operation
    typedef enum logic [1:0] {
        SPOP_HOLD  = 2'd0,
        SPOP_WRITE = 2'd1,
        SPOP_INC   = 2'd2,
        SPOP_DEC   = 2'd3
    } sp_op_e;

endpackage

// File: rtl/flag_latch_dec.sv
// Module flag_latch_dec
// Decodes the shared control bits into single-flag latch strobes.
// Assumes: the shared bits mean a latch code only while the bus
// interface is disabled (bif_off = 1); otherwise they belong to the
// bus interface and no strobe is produced.
module flag_latch_dec
    import msw_sp_pkg::*;
(
    input  logic       bif_off,
    input  logic [1:0] code,
    output logic       set_imask,
    output logic       set_sup
);

    latch_code_e code_e;

    // Interpret the raw bits as a latch code
    always_comb code_e = latch_code_e'(code);

    // Produce at most one strobe, only when the interface is off
    always_comb begin
        set_imask = 1'b0;
        set_sup   = 1'b0;
        if (bif_off) begin
            unique case (code_e)
                LT_IMASK: set_imask = 1'b1;
                LT_SUP:   set_sup   = 1'b1;
                LT_SPARE: ;
                LT_NONE:  ;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/status_word.sv
// Module status_word
// Holds the status word. A whole-word load wins over a single-flag
// latch. A flag latch copies the flag value into one bit only.
// Assumes: at most one of set_imask / set_sup is high; reset is
// synchronous and active low.
module status_word #(
    parameter int W      = 16,
    parameter int SUP_POS = 5,
    parameter int IM_POS  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         set_imask,
    input  logic         set_sup,
    input  logic         flag_val,
    output logic [W-1:0] msw
);

    localparam logic [W-1:0] RESET_VAL = W'(1) << IM_POS;

    // Status word register with load-over-latch priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msw <= RESET_VAL;
        end else if (load) begin
            msw <= din;
        end else if (set_imask) begin
            msw[IM_POS] <= flag_val;
        end else if (set_sup) begin
            msw[SUP_POS] <= flag_val;
        end
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (msw == $past(din)))
        else $error("load did not win"); // R5

    AST_IMASK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && set_imask) |=> (msw[IM_POS] == $past(flag_val)))
        else $error("imask latch"); // R2

    AST_SUP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && set_sup) |=> (msw[SUP_POS] == $past(flag_val)))
        else $error("sup latch"); // R3

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !set_imask && !set_sup) |=> $stable(msw))
        else $error("status word changed"); // R4

endmodule

// File: rtl/sp_bank.sv
// Module sp_bank
// Two physical stack pointers behind one logical pointer. The mode
// input picks the bank for reads and updates; the other bank holds.
// Assumes: kern_sel reflects the supervisor flag before the edge.
module sp_bank
    import msw_sp_pkg::*;
#(
    parameter int W     = 16,
    parameter int BANKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kern_sel,
    input  logic [1:0]   op,
    input  logic [W-1:0] din,
    output logic [W-1:0] sp_q
);

    localparam int KERN = 0;
    localparam int USER = 1;

    logic [W-1:0] bank_q [BANKS];
    logic [W-1:0] next_val;
    sp_op_e       op_e;
    logic         sel_idx;

    // Decode the operation and the active bank
    always_comb begin
        op_e    = sp_op_e'(op);
        sel_idx = kern_sel ? 1'(KERN) : 1'(USER);
        sp_q    = bank_q[sel_idx];
    end

    // Compute the updated value of the active pointer
    always_comb begin
        unique case (op_e)
            SPOP_WRITE: next_val = din;
            SPOP_INC:   next_val = sp_q + W'(1);
            SPOP_DEC:   next_val = sp_q - W'(1);
            default:    next_val = sp_q;
        endcase
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // One pointer register, updated only when its bank is active
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[b] <= '0;
            end else if (sel_idx == 1'(b)) begin
                bank_q[b] <= next_val;
            end
        end
    end

    AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        kern_sel |=> $stable(bank_q[USER]))
        else $error("user bank touched in kernel mode"); // R7

    AST_KERN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !kern_sel |=> $stable(bank_q[KERN]))
        else $error("kernel bank touched in user mode"); // R7

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == SPOP_INC) && kern_sel |=> (bank_q[KERN] == $past(bank_q[KERN]) + W'(1)))
        else $error("kernel increment"); // R6

endmodule

// File: rtl/rbus_tap.sv
// Module rbus_tap
// Places the status word on the right operand bus for one select code.
// Assumes: the bus outside merges sources by their enables.
module rbus_tap #(
    parameter int W      = 16,
    parameter int SEL_W  = 3,
    parameter int MY_SEL = 1
) (
    input  logic [SEL_W-1:0] rsel,
    input  logic [W-1:0]     msw,
    output logic [W-1:0]     rbus_q,
    output logic             rbus_oe
);

    // Drive the word only when selected, zeros otherwise
    always_comb begin
        rbus_oe = (rsel == SEL_W'(MY_SEL));
        rbus_q  = rbus_oe ? msw : '0;
    end

endmodule

// File: rtl/msw_sp_bank.sv
// Module msw_sp_bank (top)
// Status word with active-low supervisor and interrupt-mask flags,
// single-flag latching via shared control bits, and a stack pointer
// banked invisibly on the supervisor flag.
// Assumes: synchronous active-low reset; the ALU bus carries all
// zeros or all ones during a flag latch (bit 0 is used).
module msw_sp_bank #(
    parameter int W       = 16,
    parameter int SUP_POS = 5,
    parameter int IM_POS  = 4,
    parameter int SEL_W   = 3,
    parameter int MSW_SEL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bif_off,
    input  logic [1:0]       ctl_mode,
    input  logic [W-1:0]     alu_bus,
    input  logic             msw_load,
    input  logic [W-1:0]     msw_din,
    input  logic [1:0]       sp_op,
    input  logic [W-1:0]     sp_din,
    input  logic [SEL_W-1:0] rsel,
    output logic [W-1:0]     sp_q,
    output logic [W-1:0]     msw_q,
    output logic             sup_n,
    output logic             imask_n,
    output logic [W-1:0]     rbus_q,
    output logic             rbus_oe
);

    logic set_imask;
    logic set_sup;
    logic kern_sel;

    flag_latch_dec u_dec (
        .bif_off   (bif_off),
        .code      (ctl_mode),
        .set_imask (set_imask),
        .set_sup   (set_sup)
    );

    status_word #(.W(W), .SUP_POS(SUP_POS), .IM_POS(IM_POS)) u_msw (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (msw_load),
        .din       (msw_din),
        .set_imask (set_imask),
        .set_sup   (set_sup),
        .flag_val  (alu_bus[0]),
        .msw       (msw_q)
    );

    // Flag views and bank select taken from the registered word
    always_comb begin
        sup_n    = msw_q[SUP_POS];
        imask_n  = msw_q[IM_POS];
        kern_sel = !msw_q[SUP_POS];
    end

    sp_bank #(.W(W), .BANKS(2)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .kern_sel (kern_sel),
        .op       (sp_op),
        .din      (sp_din),
        .sp_q     (sp_q)
    );

    rbus_tap #(.W(W), .SEL_W(SEL_W), .MY_SEL(MSW_SEL)) u_tap (
        .rsel    (rsel),
        .msw     (msw_q),
        .rbus_q  (rbus_q),
        .rbus_oe (rbus_oe)
    );

    AST_RBUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel != SEL_W'(MSW_SEL)) |-> (!rbus_oe && rbus_q == '0))
        else $error("right bus driven while unselected"); // R8

    AST_SP_WRITE_OLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'd1) |=> ((sup_n == $past(sup_n)) -> (sp_q == $past(sp_din))))
        else $error("write lost"); // R9

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (msw_q == (W'(1) << IM_POS) && sp_q == '0))
        else $error("reset state"); // R1

endmodule

// File: tb/msw_sp_bank_test.sv
// Bench msw_sp_bank_test: behavioural model compared on every clock.
module msw_sp_bank_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bif_off;
    logic [1:0]  ctl_mode;
    logic [15:0] alu_bus;
    logic        msw_load;
    logic [15:0] msw_din;
    logic [1:0]  sp_op;
    logic [15:0] sp_din;
    logic [2:0]  rsel;
    logic [15:0] sp_q, msw_q, rbus_q;
    logic        sup_n, imask_n, rbus_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    logic [15:0] m_msw;
    logic [15:0] m_ksp;
    logic [15:0] m_usp;

    always #5 clk = ~clk;

    msw_sp_bank uut (
        .clk(clk), .rst_n(rst_n), .bif_off(bif_off), .ctl_mode(ctl_mode),
        .alu_bus(alu_bus), .msw_load(msw_load), .msw_din(msw_din),
        .sp_op(sp_op), .sp_din(sp_din), .rsel(rsel), .sp_q(sp_q),
        .msw_q(msw_q), .sup_n(sup_n), .imask_n(imask_n),
        .rbus_q(rbus_q), .rbus_oe(rbus_oe)
    );

    // Compare every output against the model
    task automatic compare(input string req);
        logic [15:0] e_sp;
        logic [15:0] e_rb;
        logic        e_oe;
        e_sp = m_msw[5] ? m_usp : m_ksp;
        e_oe = (rsel == 3'd1);
        e_rb = e_oe ? m_msw : 16'h0;
        checks++;
        if (msw_q !== m_msw || sp_q !== e_sp || rbus_q !== e_rb ||
            rbus_oe !== e_oe || sup_n !== m_msw[5] || imask_n !== m_msw[4]) begin
            failures++;
            $display("FAIL %s: msw=%h sp=%h rb=%h oe=%b exp msw=%h sp=%h rb=%h oe=%b",
                     req, msw_q, sp_q, rbus_q, rbus_oe, m_msw, e_sp, e_rb, e_oe);
        end
    endtask

    // Drive one cycle, advance model, check after the edge
    task automatic step(input string req, input logic off, input logic [1:0] mode,
                        input logic fv, input logic ld, input logic [15:0] ldv,
                        input logic [1:0] op, input logic [15:0] spv,
                        input logic [2:0] rs);
        logic [15:0] cur;
        logic [15:0] nxt;
        bif_off  = off;
        ctl_mode = mode;
        alu_bus  = fv ? 16'hFFFF : 16'h0000;
        msw_load = ld;
        msw_din  = ldv;
        sp_op    = op;
        sp_din   = spv;
        rsel     = rs;
        cur = m_msw[5] ? m_usp : m_ksp;
        case (op)
            2'd1:    nxt = spv;
            2'd2:    nxt = cur + 16'd1;
            2'd3:    nxt = cur - 16'd1;
            default: nxt = cur;
        endcase
        if (m_msw[5]) m_usp = nxt; else m_ksp = nxt;
        if (ld)                      m_msw = ldv;
        else if (off && mode == 2'd0) m_msw[4] = fv;
        else if (off && mode == 2'd1) m_msw[5] = fv;
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bif_off = 0; ctl_mode = 0; alu_bus = 0; msw_load = 0;
        msw_din = 0; sp_op = 0; sp_din = 0; rsel = 0;
        m_msw = 16'h0010; m_ksp = 0; m_usp = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        // R6: kernel-mode pointer work
        step("R6", 0, 2'd3, 0, 0, 0, 2'd1, 16'h8000, 3'd0);
        step("R6", 0, 2'd3, 0, 0, 0, 2'd2, 0, 3'd0);
        step("R6", 0, 2'd3, 0, 0, 0, 2'd3, 0, 3'd0);
        step("R6", 0, 2'd3, 0, 0, 0, 2'd3, 0, 3'd0);
        // R2: unmask then mask interrupts
        step("R2", 1, 2'd0, 0, 0, 0, 2'd0, 0, 3'd1);
        step("R2", 1, 2'd0, 1, 0, 0, 2'd0, 0, 3'd1);
        step("R2", 1, 2'd0, 0, 0, 0, 2'd0, 0, 3'd1);
        // R4: spare/none codes and interface-on cycles ignored
        step("R4", 1, 2'd2, 1, 0, 0, 2'd0, 0, 3'd1);
        step("R4", 1, 2'd3, 1, 0, 0, 2'd0, 0, 3'd1);
        step("R4", 0, 2'd0, 1, 0, 0, 2'd0, 0, 3'd1);
        step("R4", 0, 2'd1, 1, 0, 0, 2'd0, 0, 3'd1);
        // R3: enter user mode, user pointer visible
        step("R3", 1, 2'd1, 1, 0, 0, 2'd0, 0, 3'd0);
        step("R6", 0, 2'd3, 0, 0, 0, 2'd1, 16'h0100, 3'd0);
        step("R6", 0, 2'd3, 0, 0, 0, 2'd3, 0, 3'd0);
        // R7: back to kernel, kernel pointer kept
        step("R7", 1, 2'd1, 0, 0, 0, 2'd0, 0, 3'd0);
        step("R7", 0, 2'd3, 0, 0, 0, 2'd2, 0, 3'd0);
        step("R7", 1, 2'd1, 1, 0, 0, 2'd0, 0, 3'd0);
        // R9: operation together with a mode flip
        step("R9", 1, 2'd1, 0, 0, 0, 2'd3, 0, 3'd0);
        step("R9", 1, 2'd1, 1, 0, 0, 2'd1, 16'h1234, 3'd0);
        step("R9", 0, 2'd3, 0, 1, 16'h0000, 2'd2, 0, 3'd0);
        // R5: load wins over a latch of the opposite value
        step("R5", 1, 2'd0, 0, 1, 16'hA5FF, 2'd0, 0, 3'd1);
        step("R5", 1, 2'd1, 1, 1, 16'h5A00, 2'd0, 0, 3'd1);
        step("R5", 1, 2'd1, 0, 1, 16'hFFFF, 2'd0, 0, 3'd1);
        // R8: every select value
        for (int s = 0; s < 8; s++) step("R8", 0, 2'd3, 0, 0, 0, 2'd0, 0, 3'(s));
        // Mixed run (R9 coincidences among them)
        for (int i = 0; i < 1500; i++) begin
            step("R9", 1'($urandom), 2'($urandom), 1'($urandom),
                 ($urandom % 8) == 0, 16'($urandom), 2'($urandom),
                 16'($urandom), 3'($urandom));
        end
        // R1 again: reset from a disturbed state
        rst_n = 1'b0;
        m_msw = 16'h0010; m_ksp = 0; m_usp = 0;
        @(posedge clk);
        @(negedge clk);
        compare("R1");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule